// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control unit of a small accumulator machine. It walks every instruction through a fixed sequence of register transfers: fetch, an optional indirect cycle, execute, and an interrupt check. It uses a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. It drives one synchronous memory port. Each read is a one-cycle strobe, and the sequencer then waits for a valid response before it latches the returned word, so slow memories need no other handshake.

Instructions are 16-bit words. Bits 15:12 hold the operation, bit 11 selects indirect addressing, and bits 10:0 hold the address. A three-bit status word holds the zero flag, interrupt enable and supervisor mode. Only loads and adds change the zero flag. An interrupt is taken between instructions. On entry the sequencer saves the return address and the status word to fixed locations, acknowledges the request, switches to supervisor mode with interrupts off, and jumps through a vector. A return instruction reads both saved values back.

Top module: `ics_core`

## Requirements
- R1: While reset is held, the status output is 0 and no read, write or acknowledge is driven. The first read after reset fetches address 0.
- R2: Each instruction is fetched with one read at the current program counter. The program counter then advances by one, so instructions run from consecutive addresses until a jump.
- R3: Every read waits for mem_valid before its data is used. Extra response latency changes only the timing, never the results.
- R4: Opcode 1 (load) copies the addressed word into the accumulator. Opcode 3 (add) adds the word to it modulo 2^16. Both set the zero flag (status bit 0) to 1 exactly when the result is 0. Opcode 2 (store) writes the accumulator to the addressed word.
- R5: When bit 11 is set on a load, store, add, jump or jump-if-zero, the word at the address field is read first. Its bits 10:0 become the effective address, and its upper bits are ignored.
- R6: Opcode 4 always jumps to the effective address. Opcode 5 jumps only when the zero flag is 1, and otherwise falls through.
- R7: Opcode 6 sets interrupt enable (status bit 1) and opcode 7 clears it. Store, jump and these opcodes leave the zero flag unchanged.
- R8: With irq high and interrupt enable set at the end of an instruction, the sequencer performs three memory operations in order. It writes the next program counter to 0x7F0. It writes the status word to 0x7F1 (bit 0 zero, bit 1 enable, bit 2 supervisor) while it pulses irq_ack for one cycle. It then loads the program counter from bits 10:0 of 0x7F2. After entry, interrupt enable is 0 and supervisor (status bit 2) is 1.
- R9: A request that arrives while interrupt enable is 0 is ignored. No acknowledge is given and execution continues.
- R10: Opcode 8 restores the status word from 0x7F1 and the program counter from 0x7F0.
- R11: A read and a write are never issued in the same cycle, and each read strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 11 | Memory address, driven from the address register |
| mem_rd | output | 1 | One-cycle read request |
| mem_wr | output | 1 | One-cycle write request |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data returned by memory |
| mem_valid | input | 1 | Read data valid |
| irq | input | 1 | Level interrupt request |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| status_o | output | 3 | Status word: bit 0 zero, bit 1 interrupt enable, bit 2 supervisor |

## Verification
The assertions check the following on every cycle: reads and writes never overlap, each read strobe is a single cycle, the program counter advances in each fetch cycle, the buffer register holds while a response is outstanding, the zero flag changes only on a load/add result or a restore, and each acknowledge comes with interrupt enable set and is followed by supervisor mode with interrupts off. The bench scenarios are the only way to show the results of whole programs. These include the arithmetic and its zero results, both branch outcomes, indirect pointers with junk in their upper bits, the saved return address and status word, restoration on return, and identical results when the memory stretches its latency.

// File: rtl/ics_pkg.sv
package ics_pkg;

   localparam int OP_W  = 4;
   localparam int SW_W  = 3;
   localparam int SW_Z  = 0;
   localparam int SW_IE = 1;
   localparam int SW_SUP = 2;

   localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
   localparam logic [OP_W-1:0] OP_LOAD = 4'd1;
   localparam logic [OP_W-1:0] OP_STOR = 4'd2;
   localparam logic [OP_W-1:0] OP_ADD  = 4'd3;
   localparam logic [OP_W-1:0] OP_JMP  = 4'd4;
   localparam logic [OP_W-1:0] OP_JZ   = 4'd5;
   localparam logic [OP_W-1:0] OP_EI   = 4'd6;
   localparam logic [OP_W-1:0] OP_DI   = 4'd7;
   localparam logic [OP_W-1:0] OP_RTI  = 4'd8;

   typedef enum logic [4:0] {
      S_FETCH_ADR, S_FETCH_RD, S_FETCH_WT, S_DECODE,
      S_IND_RD, S_IND_WT, S_IND_MAR, S_EXEC,
      S_OPR_RD, S_OPR_WT, S_ST_WR,
      S_RTI_SW_RD, S_RTI_SW_WT, S_RTI_PC_RD, S_RTI_PC_WT,
      S_INT_CHK, S_SAVE_PC_WR, S_SAVE_SW_WR, S_VEC_RD, S_VEC_WT
   } ics_state_e;

   function automatic logic op_has_addr(input logic [OP_W-1:0] op);
      return (op == OP_LOAD) || (op == OP_STOR) || (op == OP_ADD) ||
             (op == OP_JMP) || (op == OP_JZ);
   endfunction

endpackage

// File: rtl/ics_status.sv
module ics_status
   import ics_pkg::*;
#(
   parameter bit IE_AT_RESET = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            z_we,
   input  logic            z_val,
   input  logic            ie_set,
   input  logic            ie_clr,
   input  logic            int_enter,
   input  logic            sw_load,
   input  logic [SW_W-1:0] sw_load_val,
   output logic [SW_W-1:0] sw_word
);

   logic [SW_W-1:0] rst_word;
   logic [SW_W-1:0] sw_q;

   generate
      if (IE_AT_RESET) begin : g_rst_ie_on
         assign rst_word = SW_W'(1) << SW_IE;
      end else begin : g_rst_ie_off
         assign rst_word = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= rst_word;
      end else if (sw_load) begin
         sw_q <= sw_load_val;
      end else begin
         if (z_we) sw_q[SW_Z] <= z_val;
         if (int_enter) begin
            sw_q[SW_IE]  <= 1'b0;
            sw_q[SW_SUP] <= 1'b1;
         end else if (ie_set) begin
            sw_q[SW_IE] <= 1'b1;
         end else if (ie_clr) begin
            sw_q[SW_IE] <= 1'b0;
         end
      end
   end

   assign sw_word = sw_q;

   // R8: entry leaves supervisor mode on with interrupts disabled
   a_r8_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
      int_enter |=> (!sw_q[SW_IE] && sw_q[SW_SUP]));

   // R7: zero flag moves only with a result or a restore
   a_r7_z_only_on_result: assert property (@(posedge clk) disable iff (!rst_n)
      (!z_we && !sw_load) |=> $stable(sw_q[SW_Z]));

endmodule

// File: rtl/ics_ctrl.sv
module ics_ctrl
   import ics_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 11,
   parameter int RESET_PC    = 0,
   parameter int SAVE_PC_LOC = 'h7F0,
   parameter int SAVE_SW_LOC = 'h7F1,
   parameter int VECTOR_LOC  = 'h7F2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_valid,
   input  logic              irq,
   output logic              irq_ack,
   input  logic [SW_W-1:0]   sw_word,
   output logic              z_we,
   output logic              z_val,
   output logic              ie_set,
   output logic              ie_clr,
   output logic              int_enter,
   output logic              sw_load,
   output logic [SW_W-1:0]   sw_load_val
);

   localparam int IND_BIT = DATA_W - OP_W - 1;
   localparam logic [ADDR_W-1:0] PC_RST  = ADDR_W'(RESET_PC);
   localparam logic [ADDR_W-1:0] A_SVPC  = ADDR_W'(SAVE_PC_LOC);
   localparam logic [ADDR_W-1:0] A_SVSW  = ADDR_W'(SAVE_SW_LOC);
   localparam logic [ADDR_W-1:0] A_VEC   = ADDR_W'(VECTOR_LOC);

   ics_state_e        state_q, state_d;
   logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
   logic [DATA_W-1:0] mbr_q, mbr_d, ir_q, ir_d, acc_q, acc_d;
   logic [OP_W-1:0]   ir_op, mbr_op;
   logic [DATA_W-1:0] sum;
   logic              unused_ir;

   assign ir_op     = ir_q[DATA_W-1 -: OP_W];
   assign mbr_op    = mbr_q[DATA_W-1 -: OP_W];
   assign unused_ir = ^ir_q[IND_BIT:0];
   assign sum       = (ir_op == OP_LOAD) ? mem_rdata : (acc_q + mem_rdata);

   always_comb begin
      state_d     = state_q;
      pc_d        = pc_q;
      mar_d       = mar_q;
      mbr_d       = mbr_q;
      ir_d        = ir_q;
      acc_d       = acc_q;
      z_we        = 1'b0;
      z_val       = 1'b0;
      ie_set      = 1'b0;
      ie_clr      = 1'b0;
      int_enter   = 1'b0;
      sw_load     = 1'b0;
      sw_load_val = mem_rdata[SW_W-1:0];
      unique case (state_q)
         S_FETCH_ADR: begin
            mar_d   = pc_q;
            state_d = S_FETCH_RD;
         end
         S_FETCH_RD: begin
            pc_d    = pc_q + ADDR_W'(1);
            state_d = S_FETCH_WT;
         end
         S_FETCH_WT: if (mem_valid) begin
            mbr_d   = mem_rdata;
            state_d = S_DECODE;
         end
         S_DECODE: begin
            ir_d    = mbr_q;
            mar_d   = mbr_q[ADDR_W-1:0];
            state_d = (op_has_addr(mbr_op) && mbr_q[IND_BIT]) ? S_IND_RD : S_EXEC;
         end
         S_IND_RD: state_d = S_IND_WT;
         S_IND_WT: if (mem_valid) begin
            mbr_d   = mem_rdata;
            state_d = S_IND_MAR;
         end
         S_IND_MAR: begin
            mar_d   = mbr_q[ADDR_W-1:0];
            state_d = S_EXEC;
         end
         S_EXEC: begin
            state_d = S_INT_CHK;
            case (ir_op)
               OP_LOAD, OP_ADD: state_d = S_OPR_RD;
               OP_STOR: begin
                  mbr_d   = acc_q;
                  state_d = S_ST_WR;
               end
               OP_JMP: pc_d = mar_q;
               OP_JZ:  if (sw_word[SW_Z]) pc_d = mar_q;
               OP_EI:  ie_set = 1'b1;
               OP_DI:  ie_clr = 1'b1;
               OP_RTI: begin
                  mar_d   = A_SVSW;
                  state_d = S_RTI_SW_RD;
               end
               default: ;
            endcase
         end
         S_OPR_RD: state_d = S_OPR_WT;
         S_OPR_WT: if (mem_valid) begin
            mbr_d   = mem_rdata;
            acc_d   = sum;
            z_we    = 1'b1;
            z_val   = (sum == '0);
            state_d = S_INT_CHK;
         end
         S_ST_WR: state_d = S_INT_CHK;
         S_RTI_SW_RD: state_d = S_RTI_SW_WT;
         S_RTI_SW_WT: if (mem_valid) begin
            sw_load = 1'b1;
            mar_d   = A_SVPC;
            state_d = S_RTI_PC_RD;
         end
         S_RTI_PC_RD: state_d = S_RTI_PC_WT;
         S_RTI_PC_WT: if (mem_valid) begin
            pc_d    = mem_rdata[ADDR_W-1:0];
            state_d = S_INT_CHK;
         end
         S_INT_CHK: begin
            if (irq && sw_word[SW_IE]) begin
               mar_d   = A_SVPC;
               mbr_d   = DATA_W'(pc_q);
               state_d = S_SAVE_PC_WR;
            end else begin
               state_d = S_FETCH_ADR;
            end
         end
         S_SAVE_PC_WR: begin
            mar_d   = A_SVSW;
            mbr_d   = DATA_W'(sw_word);
            state_d = S_SAVE_SW_WR;
         end
         S_SAVE_SW_WR: begin
            int_enter = 1'b1;
            mar_d     = A_VEC;
            state_d   = S_VEC_RD;
         end
         S_VEC_RD: state_d = S_VEC_WT;
         S_VEC_WT: if (mem_valid) begin
            pc_d    = mem_rdata[ADDR_W-1:0];
            state_d = S_FETCH_ADR;
         end
         default: state_d = S_FETCH_ADR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_FETCH_ADR;
         pc_q    <= PC_RST;
         mar_q   <= '0;
         mbr_q   <= '0;
         ir_q    <= '0;
         acc_q   <= '0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         mar_q   <= mar_d;
         mbr_q   <= mbr_d;
         ir_q    <= ir_d;
         acc_q   <= acc_d;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mbr_q;
   assign mem_rd    = (state_q == S_FETCH_RD) || (state_q == S_IND_RD) ||
                      (state_q == S_OPR_RD) || (state_q == S_RTI_SW_RD) ||
                      (state_q == S_RTI_PC_RD) || (state_q == S_VEC_RD);
   assign mem_wr    = (state_q == S_ST_WR) || (state_q == S_SAVE_PC_WR) ||
                      (state_q == S_SAVE_SW_WR);
   assign irq_ack   = (state_q == S_SAVE_SW_WR);

   // R11: never a read and a write together
   a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R11: a read strobe lasts one cycle
   a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R2: fetch advances the program counter by one
   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH_RD) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

   // R3: buffer register holds while a response is outstanding
   a_r3_hold_mbr: assert property (@(posedge clk) disable iff (!rst_n)
      (((state_q == S_FETCH_WT) || (state_q == S_IND_WT) || (state_q == S_OPR_WT))
       && !mem_valid) |=> $stable(mbr_q));

   // R9: acknowledge only with interrupts enabled
   a_r9_ack_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> sw_word[SW_IE]);

endmodule

// File: rtl/ics_core.sv
module ics_core
   import ics_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 11,
   parameter int RESET_PC    = 0,
   parameter int SAVE_PC_LOC = 'h7F0,
   parameter int SAVE_SW_LOC = 'h7F1,
   parameter int VECTOR_LOC  = 'h7F2,
   parameter bit IE_AT_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_valid,
   input  logic              irq,
   output logic              irq_ack,
   output logic [SW_W-1:0]   status_o
);

   localparam int ADDR_SPACE = 1 << ADDR_W;

   generate
      if (ADDR_W > DATA_W - OP_W - 1) begin : g_bad_addr_w
         $error("ics_core: address field does not fit the instruction word");
      end
      if (DATA_W < ADDR_W || DATA_W < SW_W) begin : g_bad_data_w
         $error("ics_core: data word narrower than an address or status word");
      end
      if (SAVE_PC_LOC >= ADDR_SPACE || SAVE_SW_LOC >= ADDR_SPACE ||
          VECTOR_LOC >= ADDR_SPACE || RESET_PC >= ADDR_SPACE) begin : g_bad_loc
         $error("ics_core: fixed location outside the address space");
      end
   endgenerate

   logic            z_we, z_val, ie_set, ie_clr, int_enter, sw_load;
   logic [SW_W-1:0] sw_load_val, sw_word;

   ics_ctrl #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .RESET_PC    (RESET_PC),
      .SAVE_PC_LOC (SAVE_PC_LOC),
      .SAVE_SW_LOC (SAVE_SW_LOC),
      .VECTOR_LOC  (VECTOR_LOC)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_addr    (mem_addr),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .mem_valid   (mem_valid),
      .irq         (irq),
      .irq_ack     (irq_ack),
      .sw_word     (sw_word),
      .z_we        (z_we),
      .z_val       (z_val),
      .ie_set      (ie_set),
      .ie_clr      (ie_clr),
      .int_enter   (int_enter),
      .sw_load     (sw_load),
      .sw_load_val (sw_load_val)
   );

   ics_status #(
      .IE_AT_RESET (IE_AT_RESET)
   ) i_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .z_we        (z_we),
      .z_val       (z_val),
      .ie_set      (ie_set),
      .ie_clr      (ie_clr),
      .int_enter   (int_enter),
      .sw_load     (sw_load),
      .sw_load_val (sw_load_val),
      .sw_word     (sw_word)
   );

   assign status_o = sw_word;

endmodule

// File: tb/test_ics_core.sv
module test_ics_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_valid = 1'b0;
   logic        irq = 1'b0;
   logic        irq_ack;
   logic [2:0]  status_o;

   always #5 clk = ~clk;

   ics_core i_ics_core (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_valid(mem_valid), .irq(irq), .irq_ack(irq_ack), .status_o(status_o));

   logic [15:0] mem [0:2047];
   logic        prog_we = 1'b0;
   logic [10:0] prog_addr = '0;
   logic [15:0] prog_data = '0;
   logic        clr_req = 1'b0;
   logic        irq_set = 1'b0;
   int          extra_lat = 0;
   int          p_cnt = 0;
   logic        p_busy = 1'b0;
   logic [10:0] p_addr = '0;
   int          ack_cnt = 0, both_cnt = 0, dbl_rd_cnt = 0;
   logic        prev_rd = 1'b0;
   logic        first_seen = 1'b0;
   logic [10:0] first_addr = '0;

   int  n_checks = 0, n_fail = 0;
   bit  done = 1'b0;

   always @(posedge clk) begin
      if (clr_req) begin
         for (int i = 0; i < 2048; i++) mem[i] <= '0;
         ack_cnt <= 0; both_cnt <= 0; dbl_rd_cnt <= 0; first_seen <= 1'b0;
         p_busy <= 1'b0; mem_valid <= 1'b0;
      end else begin
         if (prog_we) mem[prog_addr] <= prog_data;
         if (mem_wr) mem[mem_addr] <= mem_wdata;
         if (irq_ack) ack_cnt <= ack_cnt + 1;
         if (mem_rd && mem_wr) both_cnt <= both_cnt + 1;
         if (mem_rd && prev_rd) dbl_rd_cnt <= dbl_rd_cnt + 1;
         if (mem_rd && !first_seen) begin
            first_seen <= 1'b1;
            first_addr <= mem_addr;
         end
         if (mem_rd) begin
            if (extra_lat == 0) begin
               mem_valid <= 1'b1;
               mem_rdata <= mem[mem_addr];
            end else begin
               mem_valid <= 1'b0;
               p_busy <= 1'b1;
               p_cnt <= extra_lat - 1;
               p_addr <= mem_addr;
            end
         end else if (p_busy) begin
            if (p_cnt == 0) begin
               mem_valid <= 1'b1;
               mem_rdata <= mem[p_addr];
               p_busy <= 1'b0;
            end else begin
               mem_valid <= 1'b0;
               p_cnt <= p_cnt - 1;
            end
         end else begin
            mem_valid <= 1'b0;
         end
      end
      prev_rd <= mem_rd;
      if (!rst_n) irq <= 1'b0;
      else if (irq_set) irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
   end

   function automatic logic [15:0] ins(input int op, input bit ind, input int adr);
      return {4'(op), ind, 11'(adr)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic begin_test(input int lat);
      rst_n = 1'b0;
      extra_lat = lat;
      @(posedge clk); #1;
      clr_req = 1'b1;
      @(posedge clk); #1;
      clr_req = 1'b0;
   endtask

   task automatic put(input int adr, input logic [15:0] d);
      prog_we = 1'b1; prog_addr = 11'(adr); prog_data = d;
      @(posedge clk); #1;
      prog_we = 1'b0;
   endtask

   task automatic release_reset();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      begin_test(0);
      put(0, ins(0, 0, 0));
      put(1, ins(4, 0, 1));
      check("R1 status in reset", 32'(status_o), 0);
      check("R1 no access in reset", {mem_rd, mem_wr, irq_ack}, 0);
      release_reset();
      run(20);
      check("R1 first read seen", 32'(first_seen), 1);
      check("R1 first read address", 32'(first_addr), 0);
   endtask

   task automatic load_arith(input int lat);
      begin_test(lat);
      put(0, ins(1, 0, 100)); put(1, ins(3, 0, 101)); put(2, ins(2, 0, 102));
      put(3, ins(3, 0, 103)); put(4, ins(2, 0, 104)); put(5, ins(4, 0, 5));
      put(100, 16'd5); put(101, 16'd7); put(103, 16'hFFF4); put(104, 16'h5555);
      release_reset();
   endtask

   task automatic t_arith();
      load_arith(0);
      run(200);
      check("R4 load+add stored", 32'(mem[102]), 12);
      check("R4 wrap to zero stored", 32'(mem[104]), 0);
      check("R4 zero flag set", 32'(status_o[0]), 1);
      check("R7 store/jump keep zero flag", 32'(status_o), 1);
      check("R11 no read with write", both_cnt, 0);
      check("R11 read strobes single", dbl_rd_cnt, 0);
   endtask

   task automatic t_latency();
      load_arith(3);
      run(600);
      check("R3 slow memory sum", 32'(mem[102]), 12);
      check("R3 slow memory zero", 32'(mem[104]), 0);
      check("R3 slow memory flag", 32'(status_o), 1);
      check("R11 single strobes slow", dbl_rd_cnt, 0);
   endtask

   task automatic t_branch();
      begin_test(0);
      put(0, ins(1, 0, 100)); put(1, ins(5, 0, 4)); put(2, ins(1, 0, 101));
      put(3, ins(2, 0, 110)); put(4, ins(1, 0, 102)); put(5, ins(5, 0, 8));
      put(6, ins(2, 0, 111)); put(7, ins(4, 0, 9)); put(8, ins(2, 0, 112));
      put(9, ins(4, 0, 9));
      put(100, 16'd0); put(101, 16'd9); put(102, 16'd3);
      put(110, 16'hAAAA); put(112, 16'hBBBB);
      release_reset();
      run(300);
      check("R6 taken branch skips", 32'(mem[110]), 32'hAAAA);
      check("R6 untaken branch falls through", 32'(mem[111]), 3);
      check("R6 jump skips store", 32'(mem[112]), 32'hBBBB);
      check("R2 R4 zero flag cleared", 32'(status_o), 0);
   endtask

   task automatic t_indirect();
      begin_test(0);
      put(0, ins(1, 1, 100)); put(1, ins(2, 1, 101)); put(2, ins(4, 1, 102));
      put(3, ins(2, 0, 300)); put(20, ins(2, 0, 310)); put(21, ins(4, 0, 21));
      put(100, 16'd200); put(200, 16'h1234); put(101, 16'h8301); put(102, 16'hF814);
      release_reset();
      run(300);
      check("R5 indirect load/store", 32'(mem[11'h301]), 32'h1234);
      check("R5 indirect jump target", 32'(mem[310]), 32'h1234);
      check("R5 jump skipped next", 32'(mem[300]), 0);
   endtask

   task automatic t_interrupt();
      int k;
      begin_test(0);
      put(0, ins(6, 0, 0)); put(1, ins(1, 0, 100)); put(2, ins(4, 0, 2));
      put(50, ins(1, 0, 101)); put(51, ins(2, 0, 120)); put(52, ins(8, 0, 0));
      put(100, 16'd1); put(101, 16'd0); put(120, 16'hFFFF); put(11'h7F2, 16'hF832);
      release_reset();
      run(100);
      check("R7 enable set, zero clear", 32'(status_o), 32'h2);
      irq_set = 1'b1;
      @(posedge clk); #1;
      irq_set = 1'b0;
      k = 0;
      while (!irq_ack && k < 200) begin
         run(1);
         k++;
      end
      check("R8 acknowledge seen", 32'(irq_ack), 1);
      run(1);
      check("R8 supervisor on, enable off", 32'(status_o[2:1]), 32'h2);
      run(300);
      check("R8 one acknowledge", ack_cnt, 1);
      check("R8 saved return address", 32'(mem[11'h7F0]), 2);
      check("R8 saved status word", 32'(mem[11'h7F1]), 32'h2);
      check("R8 handler ran via vector", 32'(mem[120]), 0);
      check("R10 status restored", 32'(status_o), 32'h2);
   endtask

   task automatic t_masked();
      begin_test(0);
      put(0, ins(1, 0, 100)); put(1, ins(7, 0, 0)); put(2, ins(2, 0, 130));
      put(3, ins(4, 0, 3)); put(100, 16'd7); put(11'h7F2, 16'd50);
      release_reset();
      irq_set = 1'b1;
      @(posedge clk); #1;
      irq_set = 1'b0;
      run(200);
      check("R9 no acknowledge when disabled", ack_cnt, 0);
      check("R9 execution continued", 32'(mem[130]), 7);
      check("R9 save area untouched", 32'(mem[11'h7F0]), 0);
      check("R7 disable keeps enable off", 32'(status_o), 0);
   endtask

   initial begin
      t_reset();
      t_arith();
      t_latency();
      t_branch();
      t_indirect();
      t_interrupt();
      t_masked();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule